// File: doc/BRIEF.md
# Serial Byte Relay with Shared Bit Clock

This block listens to one asynchronous serial line and repeats every character it receives on a second line. The receiver and the transmitter both run from one tick. An integer divider of the system clock makes that tick, and it runs at a fixed number of ticks per bit (three by default). Choose the divider by rounding down. The outgoing bit time is then a little shorter than the incoming one, so a continuous stream of input never builds up a backlog.

A byte that arrives while the transmitter is idle starts going out on that same tick. Otherwise it waits in a small first-in first-out store, and the transmitter takes the next stored byte on the tick where it finishes the current one. The block reports how many bytes are waiting. If a byte arrives while every entry is taken, the block throws that byte away and sets a flag that stays set until reset. A character whose stop bit reads low is reported with a one-cycle pulse and is not sent on.

Top module: `uart_relay`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `tx_line` is 1, `fifo_level` is 0 and `overflow` is 0.
- R2: Each transmitted character is one low start bit, then eight data bits with bit 0 first, then one high stop bit. Each bit lasts OVS*CLK_DIV clocks and begins on a tick.
- R3: The receiver begins a character on a high-to-low change of the synchronised line. It confirms the start bit on the following tick. A low pulse that has already ended by that tick is ignored, and the next genuine character is still received.
- R4: Forwarded bytes leave with their value unchanged and in the order they arrived. No byte is sent that was not received.
- R5: A byte completed while the transmitter is idle and nothing is stored starts out on the same tick. `fifo_level` stays 0.
- R6: A byte completed while the transmitter is busy is stored, and `fifo_level` counts the stored bytes, never above DEPTH. When incoming bit times are longer than outgoing ones, at most one byte is ever stored.
- R7: A byte that completes while DEPTH bytes are stored and none leaves in that cycle is discarded, and `overflow` is set. `overflow` stays 1 until reset.
- R8: A character whose stop bit samples low gives a one-cycle `frame_err` pulse and is not forwarded.
- R9: The receiver realigns on every start bit, so back-to-back characters whose bit time differs from OVS*CLK_DIV by about three percent are received intact.
- R10: While bytes are stored, the next character's start bit follows the previous stop bit with no idle gap. Consecutive start edges are then exactly 10*OVS*CLK_DIV clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_line | input | 1 | Incoming serial line, idle high |
| tx_line | output | 1 | Outgoing serial line, idle high |
| fifo_level | output | $clog2(DEPTH+1) | Number of bytes waiting to be sent |
| overflow | output | 1 | Sticky flag: a byte was discarded for lack of space |
| frame_err | output | 1 | One-cycle pulse on a low stop bit |

## Verification
The bench builds the relay with CLK_DIV=12, OVS=3 and DEPTH=2, which gives a 36-clock outgoing bit. It drives the input at 37 clocks per bit to show that the store is barely used. It then drives 35 clocks per bit with no pauses. With that small divider and a two-entry store, the slow build-up of the backlog, the full store, the discarded bytes and the sticky flag all occur within about a hundred characters. Drift of one clock per bit over a whole character also tests how far the receiver tolerates a rate mismatch.

// File: rtl/uart_relay.sv
module uart_relay #(
  parameter int CLK_DIV = 144,
  parameter int OVS     = 3,
  parameter int DEPTH   = 16,
  localparam int LW     = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_line,
  output logic          tx_line,
  output logic [LW-1:0] fifo_level,
  output logic          overflow,
  output logic          frame_err
);

  localparam int DW  = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int PW  = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int MID = OVS / 2;

  logic [DW-1:0] div_cnt;
  logic          tick;

  assign tick = (div_cnt == DW'(CLK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    div_cnt <= '0;
    else if (tick) div_cnt <= '0;
    else           div_cnt <= div_cnt + DW'(1);

  logic [1:0] rx_sync;
  logic       rx_s, rx_prev;

  assign rx_s = rx_sync[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rx_sync <= 2'b11;
    else        rx_sync <= {rx_sync[0], rx_line};

  logic          rx_act;
  logic [PW-1:0] rx_ph;
  logic [3:0]    rx_idx;
  logic [7:0]    rx_sh;
  logic          rx_mid, rx_done;

  assign rx_mid  = tick && rx_act && (rx_ph == PW'(MID - 1));
  assign rx_done = rx_mid && (rx_idx == 4'd9) && rx_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_prev   <= 1'b1;
      rx_act    <= 1'b0;
      rx_ph     <= '0;
      rx_idx    <= '0;
      rx_sh     <= '0;
      frame_err <= 1'b0;
    end else begin
      frame_err <= 1'b0;
      if (tick) begin
        rx_prev <= rx_s;
        if (!rx_act) begin
          if (rx_prev && !rx_s) begin
            rx_act <= 1'b1;
            rx_ph  <= '0;
            rx_idx <= '0;
          end
        end else begin
          rx_ph <= (rx_ph == PW'(OVS - 1)) ? '0 : rx_ph + PW'(1);
          if (rx_ph == PW'(MID - 1)) begin
            if (rx_idx == 4'd0) begin
              if (rx_s) rx_act <= 1'b0;
              else      rx_idx <= 4'd1;
            end else if (rx_idx == 4'd9) begin
              rx_act    <= 1'b0;
              frame_err <= !rx_s;
            end else begin
              rx_sh  <= {rx_s, rx_sh[7:1]};
              rx_idx <= rx_idx + 4'd1;
            end
          end
        end
      end
    end

  logic          tx_act;
  logic [PW-1:0] tx_ph;
  logic [3:0]    tx_idx;
  logic [8:0]    tx_sh;
  logic          tx_end, avail, pop, direct, push, wr_ok, drop;
  logic          fifo_empty, fifo_full;
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [7:0]    tx_byte;

  assign fifo_empty = (fifo_level == '0);
  assign fifo_full  = (fifo_level == LW'(DEPTH));
  assign tx_end     = tx_act && (tx_idx == 4'd9) && (tx_ph == PW'(OVS - 1));
  assign avail      = tick && (!tx_act || tx_end);
  assign pop        = avail && !fifo_empty;
  assign direct     = avail && fifo_empty && rx_done;
  assign push       = rx_done && !direct;
  assign wr_ok      = push && (!fifo_full || pop);
  assign drop       = push && fifo_full && !pop;
  assign tx_byte    = pop ? mem[rd_ptr] : rx_sh;

  always_ff @(posedge clk)
    if (wr_ok) mem[wr_ptr] <= rx_sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      fifo_level <= '0;
      overflow   <= 1'b0;
    end else begin
      if (wr_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      if (pop)   rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      if (wr_ok && !pop)      fifo_level <= fifo_level + LW'(1);
      else if (pop && !wr_ok) fifo_level <= fifo_level - LW'(1);
      if (drop) overflow <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_act  <= 1'b0;
      tx_ph   <= '0;
      tx_idx  <= '0;
      tx_sh   <= '1;
      tx_line <= 1'b1;
    end else if (tick) begin
      if (pop || direct) begin
        tx_act  <= 1'b1;
        tx_ph   <= '0;
        tx_idx  <= '0;
        tx_sh   <= {1'b1, tx_byte};
        tx_line <= 1'b0;
      end else if (avail) begin
        tx_act <= 1'b0;
      end else if (tx_act) begin
        tx_ph <= (tx_ph == PW'(OVS - 1)) ? '0 : tx_ph + PW'(1);
        if (tx_ph == PW'(OVS - 1)) begin
          tx_idx  <= tx_idx + 4'd1;
          tx_line <= tx_sh[0];
          tx_sh   <= {1'b1, tx_sh[8:1]};
        end
      end
    end

endmodule

// File: rtl/uart_relay_chk.sv
module uart_relay_chk #(
  parameter int DEPTH = 16,
  parameter int LW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          tx_line,
  input logic [LW-1:0] fifo_level,
  input logic          overflow,
  input logic          frame_err
);

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (tx_line && fifo_level == '0 && !overflow));

  p_tx_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_line != $past(tx_line)) |-> $past(tick));

  p_level_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LW'(DEPTH));

  p_level_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level != $past(fifo_level)) |->
      (fifo_level == $past(fifo_level) + LW'(1) || fifo_level + LW'(1) == $past(fifo_level)));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  p_drop_when_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> ($past(fifo_level) == LW'(DEPTH)));

  p_fe_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);

endmodule

bind uart_relay uart_relay_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .tx_line(tx_line),
  .fifo_level(fifo_level), .overflow(overflow), .frame_err(frame_err)
);

// File: tb/uart_relay_bench.sv
module uart_relay_bench;
  localparam int CLK_DIV = 12;
  localparam int OVS     = 3;
  localparam int DEPTH   = 2;
  localparam int LW      = $clog2(DEPTH + 1);
  localparam int BIT     = CLK_DIV * OVS;

  logic          clk = 0, rst_n = 0, rx = 1;
  logic          tx_line, overflow, frame_err;
  logic [LW-1:0] fifo_level;

  always #2.5 clk = ~clk;

  uart_relay #(.CLK_DIV(CLK_DIV), .OVS(OVS), .DEPTH(DEPTH)) u_uart_relay (
    .clk(clk), .rst_n(rst_n), .rx_line(rx), .tx_line(tx_line),
    .fifo_level(fifo_level), .overflow(overflow), .frame_err(frame_err)
  );

  int checks = 0, fails = 0, out_cnt = 0, fe_cnt = 0, skipped = 0, max_lvl = 0;
  longint cyc = 0;
  bit skip_mode = 0;
  logic [7:0] expq[$];

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (frame_err) fe_cnt++;
    if (int'(fifo_level) > max_lvl) max_lvl = int'(fifo_level);
  end

  task automatic send(input logic [7:0] b, input int per, input bit stop_ok, input bit keep);
    if (keep) expq.push_back(b);
    rx = 0;
    repeat (per) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      repeat (per) @(negedge clk);
    end
    rx = stop_ok;
    repeat (per) @(negedge clk);
    rx = 1;
  endtask

  initial begin : monitor
    logic       tx_prev;
    logic [7:0] got;
    longint     t0, gap_due;
    tx_prev = 1;
    gap_due = 0;
    forever begin
      @(negedge clk);
      if (rst_n && tx_prev && !tx_line) begin
        t0 = cyc;
        if (gap_due != 0) chk(t0 == gap_due, "R10", "start edge cycle", t0, gap_due);
        gap_due = (fifo_level != 0) ? t0 + 10 * BIT : 0;
        repeat (BIT / 2) @(negedge clk);
        chk(tx_line == 1'b0, "R2", "start bit level", tx_line, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (BIT) @(negedge clk);
          got[i] = tx_line;
        end
        repeat (BIT) @(negedge clk);
        chk(tx_line == 1'b1, "R2", "stop bit level", tx_line, 1);
        out_cnt++;
        if (skip_mode)
          while (expq.size() > 0 && expq[0] != got) begin
            void'(expq.pop_front());
            skipped++;
          end
        if (expq.size() == 0) chk(0, "R4", "unexpected byte", got, -1);
        else begin
          logic [7:0] e;
          e = expq.pop_front();
          chk(got == e, "R4", "forwarded byte (bit 0 sent first, R2)", got, e);
        end
        tx_prev = 1;
      end else tx_prev = tx_line;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(0, "R4", "watchdog expired", 0, 1);
    summary();
  end

  initial begin : main
    int oc, fe;
    repeat (5) @(negedge clk);
    chk(tx_line == 1'b1, "R1", "tx idle in reset", tx_line, 1);
    chk(fifo_level == 0, "R1", "level in reset", fifo_level, 0);
    chk(overflow == 1'b0, "R1", "overflow in reset", overflow, 0);
    rst_n = 1;
    repeat (50) @(negedge clk);

    max_lvl = 0;
    send(8'hA5, BIT, 1, 1);
    repeat (600) @(negedge clk);
    chk(out_cnt == 1, "R5", "bytes out after single", out_cnt, 1);
    chk(max_lvl == 0, "R5", "level with idle transmitter", max_lvl, 0);
    chk(expq.size() == 0, "R4", "pending expected", expq.size(), 0);

    max_lvl = 0;
    send(8'h01, BIT + 1, 1, 1);
    send(8'h80, BIT + 1, 1, 1);
    for (int i = 0; i < 24; i++) send(8'(i * 53 + 1), BIT + 1, 1, 1);
    repeat (800) @(negedge clk);
    chk(expq.size() == 0, "R9", "slow stream all received", expq.size(), 0);
    chk(max_lvl <= 1, "R6", "max level with slower input", max_lvl, 1);
    chk(overflow == 1'b0, "R7", "no overflow with slower input", overflow, 0);

    oc = out_cnt; fe = fe_cnt;
    send(8'h55, BIT, 0, 0);
    repeat (600) @(negedge clk);
    chk(fe_cnt == fe + 1, "R8", "frame_err pulses", fe_cnt, fe + 1);
    chk(out_cnt == oc, "R8", "bad byte not forwarded", out_cnt, oc);

    rx = 0;
    repeat (5) @(negedge clk);
    rx = 1;
    repeat (600) @(negedge clk);
    chk(out_cnt == oc, "R3", "glitch ignored", out_cnt, oc);
    chk(fe_cnt == fe + 1, "R3", "glitch gives no frame_err", fe_cnt, fe + 1);
    send(8'h3C, BIT, 1, 1);
    repeat (600) @(negedge clk);
    chk(out_cnt == oc + 1, "R3", "byte after glitch", out_cnt, oc + 1);

    skip_mode = 1; skipped = 0; max_lvl = 0;
    for (int i = 0; i < 130; i++) send(8'(i * 7 + 3), BIT - 1, 1, 1);
    repeat (3000) @(negedge clk);
    chk(max_lvl == DEPTH, "R6", "level reaches depth under faster input", max_lvl, DEPTH);
    chk(overflow == 1'b1, "R7", "overflow set", overflow, 1);
    chk(skipped > 0, "R7", "bytes discarded", skipped, 1);
    chk(expq.size() == 0, "R9", "fast stream tail received", expq.size(), 0);
    chk(fifo_level == 0, "R6", "store drained", fifo_level, 0);
    repeat (100) @(negedge clk);
    chk(overflow == 1'b1, "R7", "overflow still set", overflow, 1);

    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(overflow == 1'b0, "R1", "overflow cleared by reset", overflow, 0);
    rst_n = 1;
    repeat (10) @(negedge clk);
    summary();
  end
endmodule